// File: doc/BRIEF.md
# Acquisition Control Sequencer

This block is the run controller on a detector front-end interface board. When a start-acquisition command arrives, it first checks that the slab has been configured and that no fault is present. It then brings up the slab in a fixed order: analog supply first, then digital supply, then a single-cycle bunch-counter reset. After that it waits for the shared synchronisation strobe. This strobe makes every board in the system begin taking data on the same clock edge.

While data taking is active, the veto and event-validate inputs are passed through to the front end. Data taking ends on the first of three conditions: memory full, analog-memory saturation, or an external stop command. The block then spends one cycle in a stop state, with all enables low, and returns to idle. If the automatic-readout option is set, a readout request pulse goes out during that stop cycle.

Every power-up step lasts a programmable number of cycles. A status pair reports the current state and the cause of the most recent stop or abort.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, state_out is 0 (idle), reason_out is 0 (none), and every enable, pulse and forwarded output is low.
- R2: A start command seen in idle while cfg_done is low leaves the block idle with all enables low, and sets reason_out to 1.
- R3: A start command seen in idle with cfg_done high but a fault present leaves the block idle with all enables low. reason_out becomes 2 for over-temperature (this wins when both faults are present) or 3 for power failure.
- R4: An accepted start puts the block in state 1 (analog supply on, digital off) for S cycles, then in state 2 (both supplies on) for S cycles. S is settle_cycles, or 16 when settle_cycles is 0.
- R5: After the digital step, bunch_rst is high for exactly one cycle (state 3), and the block then waits in state 4. acq_en rises in the cycle after a sync_strobe is sampled in state 4, and never from any other state.
- R6: veto_out and valid_out follow veto_in and valid_in only while acq_en is high (state 5), and are low otherwise.
- R7: In state 5, mem_full, mem_sat or stop_cmd ends acquisition. The block goes to state 6 for one cycle with all enables low, then to idle. The priority is mem_full over mem_sat over stop_cmd, giving reason_out 4, 5 or 6. Stop inputs are ignored outside state 5.
- R8: readout_req is a one-cycle pulse in state 6, produced only if auto_readout was high when the stop was sampled.
- R9: A start command received while the block is not idle has no effect: the settle timing and reason_out are unchanged.
- R10: A fault seen in states 1 to 4 returns the block to idle on the next cycle, with all enables low and reason_out set to 2 or 3 as in R3.
- R11: An accepted start clears reason_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cmd | input | 1 | Start-acquisition command strobe |
| stop_cmd | input | 1 | External stop command |
| sync_strobe | input | 1 | Shared synchronisation strobe |
| cfg_done | input | 1 | Slab configuration complete |
| err_overtemp | input | 1 | Over-temperature fault |
| err_pwrfail | input | 1 | Power-failure fault |
| mem_full | input | 1 | Front-end memory full |
| mem_sat | input | 1 | Analog memory saturated |
| veto_in | input | 1 | No-trigger / clear-channel veto |
| valid_in | input | 1 | Event validate |
| auto_readout | input | 1 | Request readout after stop |
| settle_cycles | input | CNT_W | Cycles per power step (0 selects 16) |
| pwr_analog_en | output | 1 | Analog supply enable |
| pwr_digital_en | output | 1 | Digital supply enable |
| bunch_rst | output | 1 | Bunch-counter reset pulse |
| acq_en | output | 1 | Acquisition enable |
| veto_out | output | 1 | Forwarded veto |
| valid_out | output | 1 | Forwarded validate |
| readout_req | output | 1 | Readout request pulse |
| state_out | output | 3 | Current state code |
| reason_out | output | 3 | Last stop or abort reason |

## Verification
All outputs are decoded from the state register. A wrong state therefore appears at the ports in the next sampled cycle: a supply enable that comes up early or late, a bunch reset longer than one cycle, or acq_en rising without a preceding strobe. A timer that miscounts shifts the state 1→2 or 2→3 boundary by whole cycles, and the bench checks that boundary on both sides. A stop cause taken from the wrong source shows in reason_out during the single stop cycle.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int N_STOP = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PWR_A = 3'd1,
    ST_PWR_D = 3'd2,
    ST_BCR   = 3'd3,
    ST_ARM   = 3'd4,
    ST_ACQ   = 3'd5,
    ST_STOP  = 3'd6
  } seq_state_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_NOCFG    = 3'd1,
    RSN_OVERTEMP = 3'd2,
    RSN_PWRFAIL  = 3'd3,
    RSN_MEMFULL  = 3'd4,
    RSN_SAT      = 3'd5,
    RSN_EXTSTOP  = 3'd6
  } seq_reason_e;
endpackage

// File: rtl/acq_settle_timer.sv
module acq_settle_timer #(
  parameter int CNT_W      = 8,
  parameter int SETTLE_DEF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] settle_cfg,
  output logic             done
);
  localparam logic [CNT_W-1:0] DEF_LIMIT = CNT_W'(SETTLE_DEF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic             cnt_en;

  assign limit = (settle_cfg == '0) ? DEF_LIMIT : settle_cfg;
  assign done  = run && (cnt_q >= (limit - 1'b1));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && !done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done) |=> (cnt_q == ($past(cnt_q) + 1'b1))); // R4
endmodule

// File: rtl/acq_stop_arbiter.sv
module acq_stop_arbiter #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [N_SRC-1:0] src,
  output logic [N_SRC-1:0] grant,
  output logic             hit
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      grant[i] = active && src[i] && !seen;
      seen     = seen || src[i];
    end
  end

  assign hit = active && (|src);

  AST_STOP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_STOP_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (grant != '0)); // R7
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic              sync_strobe,
  input  logic              cfg_done,
  input  logic              err_t,
  input  logic              err_p,
  input  logic              auto_ro,
  input  logic              tmr_done,
  input  logic              stop_hit,
  input  logic [N_STOP-1:0] stop_grant,
  output seq_state_e        state_q,
  output seq_reason_e       reason_q,
  output logic              ro_q,
  output logic              tmr_clr,
  output logic              tmr_run
);
  seq_state_e  state_d;
  seq_reason_e reason_d;
  logic        reason_en;
  logic        ro_d;
  logic        pwr_phase;

  assign pwr_phase = (state_q == ST_PWR_A) || (state_q == ST_PWR_D) ||
                     (state_q == ST_BCR)   || (state_q == ST_ARM);

  always_comb begin
    state_d  = state_q;
    reason_d = reason_q;
    case (state_q)
      ST_IDLE: begin
        if (start_cmd) begin
          if (!cfg_done)  reason_d = RSN_NOCFG;
          else if (err_t) reason_d = RSN_OVERTEMP;
          else if (err_p) reason_d = RSN_PWRFAIL;
          else begin
            state_d  = ST_PWR_A;
            reason_d = RSN_NONE;
          end
        end
      end
      ST_PWR_A, ST_PWR_D, ST_BCR, ST_ARM: begin
        if (err_t) begin
          state_d  = ST_IDLE;
          reason_d = RSN_OVERTEMP;
        end else if (err_p) begin
          state_d  = ST_IDLE;
          reason_d = RSN_PWRFAIL;
        end else begin
          case (state_q)
            ST_PWR_A: if (tmr_done)    state_d = ST_PWR_D;
            ST_PWR_D: if (tmr_done)    state_d = ST_BCR;
            ST_BCR:                    state_d = ST_ARM;
            default:  if (sync_strobe) state_d = ST_ACQ;
          endcase
        end
      end
      ST_ACQ: begin
        if (stop_hit) begin
          state_d = ST_STOP;
          if (stop_grant[0])      reason_d = RSN_MEMFULL;
          else if (stop_grant[1]) reason_d = RSN_SAT;
          else                    reason_d = RSN_EXTSTOP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign reason_en = (reason_d != reason_q);
  assign ro_d      = (state_q == ST_ACQ) && stop_hit && auto_ro;
  assign tmr_clr   = (state_d != state_q);
  assign tmr_run   = (state_q == ST_PWR_A) || (state_q == ST_PWR_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      reason_q <= RSN_NONE;
      ro_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      ro_q    <= ro_d;
      if (reason_en) reason_q <= reason_d;
    end
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_phase && (err_t || err_p)) |=> (state_q == ST_IDLE)); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWR_A && start_cmd && !err_t && !err_p && !tmr_done)
      |=> (state_q == ST_PWR_A)); // R9
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_DEF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             sync_strobe,
  input  logic             cfg_done,
  input  logic             err_overtemp,
  input  logic             err_pwrfail,
  input  logic             mem_full,
  input  logic             mem_sat,
  input  logic             veto_in,
  input  logic             valid_in,
  input  logic             auto_readout,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             pwr_analog_en,
  output logic             pwr_digital_en,
  output logic             bunch_rst,
  output logic             acq_en,
  output logic             veto_out,
  output logic             valid_out,
  output logic             readout_req,
  output logic [2:0]       state_out,
  output logic [2:0]       reason_out
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  seq_state_e        state_q;
  seq_reason_e       reason_q;
  logic              ro_q;
  logic              tmr_clr;
  logic              tmr_run;
  logic              tmr_done;
  logic              stop_hit;
  logic [N_STOP-1:0] stop_src;
  logic [N_STOP-1:0] stop_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign stop_src = {stop_cmd, mem_sat, mem_full};

  acq_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start_cmd  (start_cmd),
    .sync_strobe(sync_strobe),
    .cfg_done   (cfg_done),
    .err_t      (err_overtemp),
    .err_p      (err_pwrfail),
    .auto_ro    (auto_readout),
    .tmr_done   (tmr_done),
    .stop_hit   (stop_hit),
    .stop_grant (stop_grant),
    .state_q    (state_q),
    .reason_q   (reason_q),
    .ro_q       (ro_q),
    .tmr_clr    (tmr_clr),
    .tmr_run    (tmr_run)
  );

  acq_settle_timer #(.CNT_W(CNT_W), .SETTLE_DEF(SETTLE_DEF)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .clr       (tmr_clr),
    .run       (tmr_run),
    .settle_cfg(settle_cycles),
    .done      (tmr_done)
  );

  acq_stop_arbiter #(.N_SRC(N_STOP)) u_stop (
    .clk   (clk),
    .rst_n (rst_sn),
    .active(state_q == ST_ACQ),
    .src   (stop_src),
    .grant (stop_grant),
    .hit   (stop_hit)
  );

  assign pwr_analog_en  = (state_q == ST_PWR_A) || (state_q == ST_PWR_D) ||
                          (state_q == ST_BCR)   || (state_q == ST_ARM)   ||
                          (state_q == ST_ACQ);
  assign pwr_digital_en = (state_q == ST_PWR_D) || (state_q == ST_BCR) ||
                          (state_q == ST_ARM)   || (state_q == ST_ACQ);
  assign bunch_rst      = (state_q == ST_BCR);
  assign acq_en         = (state_q == ST_ACQ);
  assign veto_out       = acq_en && veto_in;
  assign valid_out      = acq_en && valid_in;
  assign readout_req    = (state_q == ST_STOP) && ro_q;
  assign state_out      = state_q;
  assign reason_out     = reason_q;

  AST_ANALOG_FIRST: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pwr_digital_en) |-> $past(pwr_analog_en)); // R4
  AST_BCR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    bunch_rst |=> !bunch_rst); // R5
  AST_SYNC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(acq_en) |-> $past(sync_strobe)); // R5
  AST_RO_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_sn)
    readout_req |-> $past(acq_en)); // R8
  AST_STOP_ENDS_ACQ: assert property (@(posedge clk) disable iff (!rst_sn)
    (acq_en && (mem_full || mem_sat || stop_cmd)) |=> !acq_en); // R7
endmodule

// File: tb/tb_acq_sequencer.sv
module tb_acq_sequencer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_cmd, stop_cmd, sync_strobe, cfg_done;
  logic       err_overtemp, err_pwrfail, mem_full, mem_sat;
  logic       veto_in, valid_in, auto_readout;
  logic [7:0] settle_cycles;
  logic       pwr_analog_en, pwr_digital_en, bunch_rst, acq_en;
  logic       veto_out, valid_out, readout_req;
  logic [2:0] state_out, reason_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  acq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .sync_strobe(sync_strobe), .cfg_done(cfg_done),
    .err_overtemp(err_overtemp), .err_pwrfail(err_pwrfail),
    .mem_full(mem_full), .mem_sat(mem_sat), .veto_in(veto_in),
    .valid_in(valid_in), .auto_readout(auto_readout),
    .settle_cycles(settle_cycles), .pwr_analog_en(pwr_analog_en),
    .pwr_digital_en(pwr_digital_en), .bunch_rst(bunch_rst), .acq_en(acq_en),
    .veto_out(veto_out), .valid_out(valid_out), .readout_req(readout_req),
    .state_out(state_out), .reason_out(reason_out)
  );

  typedef struct packed {
    logic       cfg;
    logic       et;
    logic       ep;
    logic [1:0] stop;
    logic       ro;
    logic [7:0] settle;
    logic [2:0] rsn;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'd2, 3'd1},
    '{1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 8'd2, 3'd2},
    '{1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 8'd2, 3'd3},
    '{1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 8'd2, 3'd2},
    '{1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 8'd1, 3'd4},
    '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 8'd3, 3'd5},
    '{1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 8'd5, 3'd6},
    '{1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'd2, 3'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic go_acq();
    settle_cycles = 8'd1;
    cfg_done = 1'b1;
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    tick(3);
    chk("R5 armed before sync", state_out, 4);
    sync_strobe = 1'b1; tick(1); sync_strobe = 1'b0;
    chk("R5 acq after sync", acq_en, 1);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    cfg_done = v.cfg; err_overtemp = v.et; err_pwrfail = v.ep;
    settle_cycles = v.settle; auto_readout = v.ro;
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    if (v.rsn < 3'd4) begin
      chk($sformatf("R2/R3 vec%0d idle", idx), state_out, 0);
      chk($sformatf("R2 R3 vec%0d reason", idx), reason_out, v.rsn);
      chk($sformatf("R3 vec%0d pwr off", idx), pwr_analog_en, 0);
      err_overtemp = 1'b0; err_pwrfail = 1'b0;
      tick(1);
      return;
    end
    chk($sformatf("R11 vec%0d reason cleared", idx), reason_out, 0);
    chk($sformatf("R4 vec%0d analog step", idx), {pwr_analog_en, pwr_digital_en}, 2);
    tick(v.settle - 1);
    chk($sformatf("R4 vec%0d analog held", idx), state_out, 1);
    tick(1);
    chk($sformatf("R4 vec%0d digital step", idx), {pwr_analog_en, pwr_digital_en}, 3);
    tick(v.settle - 1);
    chk($sformatf("R4 vec%0d digital held", idx), state_out, 2);
    tick(1);
    chk($sformatf("R5 vec%0d bunch reset", idx), bunch_rst, 1);
    tick(1);
    chk($sformatf("R5 vec%0d bunch reset one cycle", idx), bunch_rst, 0);
    tick(2);
    chk($sformatf("R5 vec%0d waits for sync", idx), {state_out, acq_en}, 8);
    veto_in = 1'b1; #1;
    chk($sformatf("R6 vec%0d veto blocked", idx), veto_out, 0);
    sync_strobe = 1'b1; tick(1); sync_strobe = 1'b0;
    chk($sformatf("R5 vec%0d acquiring", idx), {state_out, acq_en}, 11);
    chk($sformatf("R6 vec%0d veto passed", idx), veto_out, 1);
    veto_in = 1'b0; valid_in = 1'b1; #1;
    chk($sformatf("R6 vec%0d validate passed", idx), {veto_out, valid_out}, 1);
    valid_in = 1'b0;
    mem_full = (v.stop == 2'd0); mem_sat = (v.stop == 2'd1); stop_cmd = (v.stop == 2'd2);
    tick(1);
    mem_full = 1'b0; mem_sat = 1'b0; stop_cmd = 1'b0;
    chk($sformatf("R7 vec%0d stop state", idx), state_out, 6);
    chk($sformatf("R7 vec%0d enables off", idx), {pwr_analog_en, pwr_digital_en, acq_en}, 0);
    chk($sformatf("R7 vec%0d reason", idx), reason_out, v.rsn);
    chk($sformatf("R8 vec%0d readout", idx), readout_req, v.ro);
    tick(1);
    chk($sformatf("R7 vec%0d back idle", idx), state_out, 0);
    chk($sformatf("R8 vec%0d readout one cycle", idx), readout_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_cmd = 0; stop_cmd = 0; sync_strobe = 0; cfg_done = 0;
    err_overtemp = 0; err_pwrfail = 0; mem_full = 0; mem_sat = 0;
    veto_in = 0; valid_in = 0; auto_readout = 0; settle_cycles = 8'd2;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    chk("R1 reset state", state_out, 0);
    chk("R1 reset reason", reason_out, 0);
    chk("R1 reset outputs", {pwr_analog_en, pwr_digital_en, bunch_rst, acq_en,
                             veto_out, valid_out, readout_req}, 0);

    for (int i = 0; i < 8; i++) run_vec(VEC[i], i);

    // R4 default settle length and R10 abort in digital step
    cfg_done = 1'b1; settle_cycles = 8'd0;
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    tick(15);
    chk("R4 default settle held", state_out, 1);
    tick(1);
    chk("R4 default settle done", state_out, 2);
    err_pwrfail = 1'b1; tick(1); err_pwrfail = 1'b0;
    chk("R10 abort idle", state_out, 0);
    chk("R10 abort enables off", {pwr_analog_en, pwr_digital_en}, 0);
    chk("R10 abort reason", reason_out, 3);

    // R9 start while busy
    settle_cycles = 8'd4;
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    tick(2);
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    chk("R9 still analog step", state_out, 1);
    chk("R9 reason unchanged", reason_out, 0);
    tick(1);
    chk("R9 settle not restarted", state_out, 2);
    tick(4);
    chk("R5 bunch reset after digital", bunch_rst, 1);
    tick(1);
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    chk("R9 arm unaffected", state_out, 4);
    err_overtemp = 1'b1; tick(1); err_overtemp = 1'b0;
    chk("R10 abort from arm", {state_out, reason_out}, 2);
    chk("R10 arm abort enables off", {pwr_analog_en, acq_en}, 0);

    // R5 sync in idle ignored
    sync_strobe = 1'b1; tick(1); sync_strobe = 1'b0;
    chk("R5 sync ignored in idle", {state_out, acq_en}, 0);

    // R7 stop inputs ignored before acquisition, priority during it
    settle_cycles = 8'd1;
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    tick(3);
    mem_full = 1'b1; stop_cmd = 1'b1; tick(1); mem_full = 1'b0; stop_cmd = 1'b0;
    chk("R7 stop ignored in arm", state_out, 4);
    auto_readout = 1'b0;
    sync_strobe = 1'b1; tick(1); sync_strobe = 1'b0;
    chk("R5 acq after sync", acq_en, 1);
    mem_sat = 1'b1; stop_cmd = 1'b1; tick(1); mem_sat = 1'b0; stop_cmd = 1'b0;
    chk("R7 sat over ext", reason_out, 5);
    chk("R8 no readout when option off", readout_req, 0);
    tick(1);
    auto_readout = 1'b1;
    go_acq();
    mem_full = 1'b1; mem_sat = 1'b1; stop_cmd = 1'b1; tick(1);
    mem_full = 1'b0; mem_sat = 1'b0; stop_cmd = 1'b0;
    chk("R7 full over all", reason_out, 4);
    chk("R8 readout pulse", readout_req, 1);
    tick(1);
    chk("R7 idle after stop", state_out, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule